// File: doc/BRIEF.md
# Pipeline Forwarding and Hazard Unit

This block is the hazard control of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). It looks at the register specifiers, write enables and load/store flags held in the stage registers. From those it drives three things: the operand bypass selects for the ALU, for the decode-stage branch comparator and for store data in the memory stage; the hold and bubble controls that stall the front end; and the squash of the single wrong-path fetch after a taken branch.

Registers are read in decode and written in writeback, so only read-after-write dependences are handled. An ALU result is bypassed from the EX/MEM or MEM/WB register with no stall. A load followed at once by a consumer costs one bubble, and the value is bypassed from MEM/WB after that. Branches resolve in decode under a predict-not-taken policy. A branch waits if its operand is still being computed in execute, or if it is still being loaded in the memory stage. The unit is purely combinational from its data inputs. The clock and reset only qualify the built-in checks.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: A bypass select is 2-bit coded: 00 = register-file value, 01 = MEM/WB value, 10 = EX/MEM value. An execute-stage select (ex_fwd_a_o for ex_rs1_i, ex_fwd_b_o for ex_rs2_i) is 10 when mem_wr_en_i=1, mem_is_load_i=0, mem_rd_i is nonzero and mem_rd_i equals the source.
- R2: When the EX/MEM case of R1 does not apply, the select is 01 if wb_wr_en_i=1, wb_rd_i is nonzero and wb_rd_i equals the source. Otherwise it is 00.
- R3: When both EX/MEM and MEM/WB qualify for the same source, the select is 10 (the younger result wins).
- R4: A source specifier of register 0 always gives select 00, whatever the stage destinations are.
- R5: A load in the memory stage (mem_is_load_i=1) is never a bypass source, so no select is 10 while it is there.
- R6: When ex_wr_en_i=1, ex_is_load_i=1, ex_rd_i is nonzero and ex_rd_i equals a decode source that is in use, the unit stalls in the same cycle: pc_hold_o=1, ifid_hold_o=1 and idex_bubble_o=1.
- R7: A decode-stage store (id_is_store_i=1) whose only match with the load in execute is its data source id_rs2_i does not stall. mem_st_fwd_o=1 when mem_is_store_i=1, wb_wr_en_i=1, and wb_rd_i is nonzero and equals mem_rs2_i. Otherwise it is 0.
- R8: The branch comparator selects id_fwd_a_o (for id_rs1_i) and id_fwd_b_o (for id_rs2_i) follow the same coding and rules as R1 to R5.
- R9: A decode branch (id_is_branch_i=1) stalls while any writer in execute targets one of its in-use nonzero sources, or while a load in the memory stage does so.
- R10: ifid_flush_o=1 exactly when id_is_branch_i=1, id_br_taken_i=1 and no stall is raised. A stalled branch never flushes.
- R11: A source whose use flag (id_use_rs1_i, id_use_rs2_i) is 0 never causes a stall.
- R12: An ALU (non-load) writer in execute that feeds a non-branch decode instruction causes no stall. When no stall cause exists, all three stall outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, qualifies the built-in checks |
| rst_ni | input | 1 | Active-low asynchronous reset |
| id_rs1_i | input | REG_AW | Decode source 1 |
| id_rs2_i | input | REG_AW | Decode source 2 |
| id_use_rs1_i | input | 1 | Decode instruction reads source 1 |
| id_use_rs2_i | input | 1 | Decode instruction reads source 2 |
| id_is_branch_i | input | 1 | Decode holds a conditional branch |
| id_is_store_i | input | 1 | Decode holds a store (source 2 is the data) |
| id_br_taken_i | input | 1 | Branch outcome from the decode comparator |
| ex_rs1_i | input | REG_AW | Execute source 1 |
| ex_rs2_i | input | REG_AW | Execute source 2 |
| ex_rd_i | input | REG_AW | Execute destination |
| ex_wr_en_i | input | 1 | Execute instruction writes a register |
| ex_is_load_i | input | 1 | Execute instruction is a load |
| mem_rs2_i | input | REG_AW | Memory-stage store data source |
| mem_rd_i | input | REG_AW | Memory-stage destination |
| mem_wr_en_i | input | 1 | Memory-stage instruction writes a register |
| mem_is_load_i | input | 1 | Memory-stage instruction is a load |
| mem_is_store_i | input | 1 | Memory-stage instruction is a store |
| wb_rd_i | input | REG_AW | Writeback destination |
| wb_wr_en_i | input | 1 | Writeback instruction writes a register |
| ex_fwd_a_o | output | 2 | ALU operand A bypass select |
| ex_fwd_b_o | output | 2 | ALU operand B bypass select |
| id_fwd_a_o | output | 2 | Branch comparator operand A select |
| id_fwd_b_o | output | 2 | Branch comparator operand B select |
| mem_st_fwd_o | output | 1 | Take store data from MEM/WB |
| pc_hold_o | output | 1 | Hold the PC |
| ifid_hold_o | output | 1 | Hold the IF/ID register |
| idex_bubble_o | output | 1 | Zero the control fields written into ID/EX |
| ifid_flush_o | output | 1 | Squash the fetched instruction |

## Verification
The bench draws specifiers from a small register range so that matches are frequent. It goes after the cases where two stages target the same register: a design that prefers MEM/WB there would feed stale data. It also covers register 0 as a destination, where a wrong design would bypass a nonexistent write. Further cases are a load in the memory stage, which must never be chosen as an ALU source, and a store whose data comes straight from the preceding load, which must not stall. Last are branches stalled behind an execute writer or a memory-stage load: a design that lets one of those through would flush on an outcome computed from an unresolved operand.

// File: rtl/phz_pkg.sv
package phz_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } byp_sel_e;

  localparam int unsigned NUM_BYP = 4;
endpackage

// File: rtl/phz_byp_sel.sv
module phz_byp_sel
  import phz_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] src_i,
  input  logic [REG_AW-1:0] mem_rd_i,
  input  logic              mem_wr_i,
  input  logic              mem_ld_i,
  input  logic [REG_AW-1:0] wb_rd_i,
  input  logic              wb_wr_i,
  output byp_sel_e          sel_o
);
  logic src_nz, mem_hit, wb_hit;

  assign src_nz  = |src_i;
  // loaded data is not ready in EX/MEM
  assign mem_hit = src_nz && mem_wr_i && !mem_ld_i && (mem_rd_i == src_i);
  assign wb_hit  = src_nz && wb_wr_i && (wb_rd_i == src_i);

  always_comb begin
    sel_o = SEL_RF;
    if (mem_hit)     sel_o = SEL_MEM;
    else if (wb_hit) sel_o = SEL_WB;
  end

  // R4
  zero_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == '0) |-> (sel_o == SEL_RF));
  // R5
  load_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_ld_i |-> (sel_o != SEL_MEM));
  // R3
  young_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_i && !mem_ld_i && mem_rd_i == src_i && src_i != '0) |-> (sel_o == SEL_MEM));
endmodule

// File: rtl/phz_stall_det.sv
module phz_stall_det #(
  parameter int unsigned REG_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] id_rs1_i,
  input  logic [REG_AW-1:0] id_rs2_i,
  input  logic              id_use1_i,
  input  logic              id_use2_i,
  input  logic              id_br_i,
  input  logic              id_st_i,
  input  logic              id_taken_i,
  input  logic [REG_AW-1:0] ex_rd_i,
  input  logic              ex_wr_i,
  input  logic              ex_ld_i,
  input  logic [REG_AW-1:0] mem_rd_i,
  input  logic              mem_wr_i,
  input  logic              mem_ld_i,
  output logic              stall_o,
  output logic              flush_o
);
  logic ex_hit1, ex_hit2, mem_hit1, mem_hit2;
  logic ld_use, br_wait;

  assign ex_hit1  = id_use1_i && ex_wr_i && (ex_rd_i != '0) && (ex_rd_i == id_rs1_i);
  assign ex_hit2  = id_use2_i && ex_wr_i && (ex_rd_i != '0) && (ex_rd_i == id_rs2_i);
  assign mem_hit1 = id_use1_i && mem_wr_i && mem_ld_i && (mem_rd_i != '0) && (mem_rd_i == id_rs1_i);
  assign mem_hit2 = id_use2_i && mem_wr_i && mem_ld_i && (mem_rd_i != '0) && (mem_rd_i == id_rs2_i);

  // store data reaches memory stage via MEM/WB bypass; no bubble for it
  assign ld_use  = ex_ld_i && (ex_hit1 || (ex_hit2 && !id_st_i));
  assign br_wait = id_br_i && (ex_hit1 || ex_hit2 || mem_hit1 || mem_hit2);

  assign stall_o = ld_use || br_wait;
  assign flush_o = id_br_i && id_taken_i && !stall_o;

  // R10
  flush_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flush_o && stall_o));
  // R11
  unused_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!id_use1_i && !id_use2_i) |-> !stall_o);
endmodule

// File: rtl/phz_store_fwd.sv
module phz_store_fwd #(
  parameter int unsigned REG_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mem_st_i,
  input  logic [REG_AW-1:0] mem_rs2_i,
  input  logic [REG_AW-1:0] wb_rd_i,
  input  logic              wb_wr_i,
  output logic              fwd_o
);
  assign fwd_o = mem_st_i && wb_wr_i && (|wb_rd_i) && (wb_rd_i == mem_rs2_i);

  // R7
  st_fwd_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_o |-> (wb_wr_i && mem_rs2_i != '0));
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import phz_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] id_rs1_i,
  input  logic [REG_AW-1:0] id_rs2_i,
  input  logic              id_use_rs1_i,
  input  logic              id_use_rs2_i,
  input  logic              id_is_branch_i,
  input  logic              id_is_store_i,
  input  logic              id_br_taken_i,
  input  logic [REG_AW-1:0] ex_rs1_i,
  input  logic [REG_AW-1:0] ex_rs2_i,
  input  logic [REG_AW-1:0] ex_rd_i,
  input  logic              ex_wr_en_i,
  input  logic              ex_is_load_i,
  input  logic [REG_AW-1:0] mem_rs2_i,
  input  logic [REG_AW-1:0] mem_rd_i,
  input  logic              mem_wr_en_i,
  input  logic              mem_is_load_i,
  input  logic              mem_is_store_i,
  input  logic [REG_AW-1:0] wb_rd_i,
  input  logic              wb_wr_en_i,
  output logic [1:0]        ex_fwd_a_o,
  output logic [1:0]        ex_fwd_b_o,
  output logic [1:0]        id_fwd_a_o,
  output logic [1:0]        id_fwd_b_o,
  output logic              mem_st_fwd_o,
  output logic              pc_hold_o,
  output logic              ifid_hold_o,
  output logic              idex_bubble_o,
  output logic              ifid_flush_o
);
  logic [REG_AW-1:0] byp_src [NUM_BYP];
  byp_sel_e          byp_sel [NUM_BYP];
  logic              stall;

  assign byp_src[0] = ex_rs1_i;
  assign byp_src[1] = ex_rs2_i;
  assign byp_src[2] = id_rs1_i;
  assign byp_src[3] = id_rs2_i;

  for (genvar g = 0; g < NUM_BYP; g++) begin : g_byp
    phz_byp_sel #(.REG_AW(REG_AW)) u_sel (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .src_i    (byp_src[g]),
      .mem_rd_i (mem_rd_i),
      .mem_wr_i (mem_wr_en_i),
      .mem_ld_i (mem_is_load_i),
      .wb_rd_i  (wb_rd_i),
      .wb_wr_i  (wb_wr_en_i),
      .sel_o    (byp_sel[g])
    );
  end

  assign ex_fwd_a_o = byp_sel[0];
  assign ex_fwd_b_o = byp_sel[1];
  assign id_fwd_a_o = byp_sel[2];
  assign id_fwd_b_o = byp_sel[3];

  phz_stall_det #(.REG_AW(REG_AW)) u_stall (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .id_rs1_i   (id_rs1_i),
    .id_rs2_i   (id_rs2_i),
    .id_use1_i  (id_use_rs1_i),
    .id_use2_i  (id_use_rs2_i),
    .id_br_i    (id_is_branch_i),
    .id_st_i    (id_is_store_i),
    .id_taken_i (id_br_taken_i),
    .ex_rd_i    (ex_rd_i),
    .ex_wr_i    (ex_wr_en_i),
    .ex_ld_i    (ex_is_load_i),
    .mem_rd_i   (mem_rd_i),
    .mem_wr_i   (mem_wr_en_i),
    .mem_ld_i   (mem_is_load_i),
    .stall_o    (stall),
    .flush_o    (ifid_flush_o)
  );

  phz_store_fwd #(.REG_AW(REG_AW)) u_stfwd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mem_st_i  (mem_is_store_i),
    .mem_rs2_i (mem_rs2_i),
    .wb_rd_i   (wb_rd_i),
    .wb_wr_i   (wb_wr_en_i),
    .fwd_o     (mem_st_fwd_o)
  );

  assign pc_hold_o     = stall;
  assign ifid_hold_o   = stall;
  assign idex_bubble_o = stall;

  // R6
  load_use_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_wr_en_i && ex_is_load_i && ex_rd_i != '0 && id_use_rs1_i && ex_rd_i == id_rs1_i)
    |-> idex_bubble_o);
  // R9
  br_mem_ld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_is_branch_i && mem_wr_en_i && mem_is_load_i && mem_rd_i != '0 &&
     id_use_rs2_i && mem_rd_i == id_rs2_i) |-> (pc_hold_o && !ifid_flush_o));
endmodule

// File: tb/pipe_hazard_ctrl_bench.sv
module pipe_hazard_ctrl_bench;
  localparam int AW = 5;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rs2, mem_rd, wb_rd;
  logic id_u1, id_u2, id_br, id_st, id_tk, ex_wr, ex_ld, mem_wr, mem_ld, mem_st, wb_wr;
  logic [1:0] ex_fa, ex_fb, id_fa, id_fb;
  logic st_fwd, pc_hold, ifid_hold, bubble, flush;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pipe_hazard_ctrl #(.REG_AW(AW)) u_pipe_hazard_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .id_rs1_i(id_rs1), .id_rs2_i(id_rs2), .id_use_rs1_i(id_u1), .id_use_rs2_i(id_u2),
    .id_is_branch_i(id_br), .id_is_store_i(id_st), .id_br_taken_i(id_tk),
    .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2), .ex_rd_i(ex_rd), .ex_wr_en_i(ex_wr),
    .ex_is_load_i(ex_ld), .mem_rs2_i(mem_rs2), .mem_rd_i(mem_rd), .mem_wr_en_i(mem_wr),
    .mem_is_load_i(mem_ld), .mem_is_store_i(mem_st), .wb_rd_i(wb_rd), .wb_wr_en_i(wb_wr),
    .ex_fwd_a_o(ex_fa), .ex_fwd_b_o(ex_fb), .id_fwd_a_o(id_fa), .id_fwd_b_o(id_fb),
    .mem_st_fwd_o(st_fwd), .pc_hold_o(pc_hold), .ifid_hold_o(ifid_hold),
    .idex_bubble_o(bubble), .ifid_flush_o(flush)
  );

  function automatic int ref_sel(logic [AW-1:0] s);
    if (s == 0) return 0;
    if (mem_wr && !mem_ld && mem_rd == s) return 2;
    if (wb_wr && wb_rd == s) return 1;
    return 0;
  endfunction

  function automatic bit ref_stall();
    bit m1, m2, l1, l2;
    m1 = id_u1 && ex_wr && ex_rd != 0 && ex_rd == id_rs1;
    m2 = id_u2 && ex_wr && ex_rd != 0 && ex_rd == id_rs2;
    l1 = id_u1 && mem_wr && mem_ld && mem_rd != 0 && mem_rd == id_rs1;
    l2 = id_u2 && mem_wr && mem_ld && mem_rd != 0 && mem_rd == id_rs2;
    if (id_br) return m1 || m2 || l1 || l2;
    if (ex_ld && m1) return 1;
    if (ex_ld && m2 && !id_st) return 1;
    return 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    {id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rs2, mem_rd, wb_rd} = '0;
    {id_u1, id_u2, id_br, id_st, id_tk, ex_wr, ex_ld, mem_wr, mem_ld, mem_st, wb_wr} = '0;
  endtask

  task automatic settle();
    @(posedge clk);
    #5;
  endtask

  task automatic check_all(string ctx);
    bit s;
    s = ref_stall();
    chk({ctx, " R1 R2 R3 R4 R5 ex_fwd_a"}, ex_fa, ref_sel(ex_rs1));
    chk({ctx, " R1 R2 R3 R4 R5 ex_fwd_b"}, ex_fb, ref_sel(ex_rs2));
    chk({ctx, " R8 id_fwd_a"}, id_fa, ref_sel(id_rs1));
    chk({ctx, " R8 id_fwd_b"}, id_fb, ref_sel(id_rs2));
    chk({ctx, " R7 st_fwd"}, st_fwd, int'(mem_st && wb_wr && wb_rd != 0 && wb_rd == mem_rs2));
    chk({ctx, " R6 R9 R11 R12 pc_hold"}, pc_hold, s);
    chk({ctx, " R6 R9 R11 R12 ifid_hold"}, ifid_hold, s);
    chk({ctx, " R6 R9 R11 R12 bubble"}, bubble, s);
    chk({ctx, " R10 flush"}, flush, int'(id_br && id_tk && !s));
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5e));
    idle();
    repeat (3) @(posedge clk);
    #5;
    chk("reset ex_fwd_a", ex_fa, 0);
    chk("reset R12 stall", pc_hold, 0);
    chk("reset R10 flush", flush, 0);
    rst_ni = 1'b1;

    // R1 EX/MEM ALU result
    settle(); idle(); ex_rs1 = 3; mem_wr = 1; mem_rd = 3; #10;
    chk("R1 mem bypass", ex_fa, 2);
    // R2 MEM/WB
    settle(); idle(); ex_rs2 = 6; wb_wr = 1; wb_rd = 6; #10;
    chk("R2 wb bypass", ex_fb, 1);
    // R3 both match
    settle(); idle(); ex_rs1 = 9; mem_wr = 1; mem_rd = 9; wb_wr = 1; wb_rd = 9; #10;
    chk("R3 younger wins", ex_fa, 2);
    // R4 register 0
    settle(); idle(); mem_wr = 1; wb_wr = 1; #10;
    chk("R4 x0 mem", ex_fa, 0);
    chk("R4 x0 id", id_fb, 0);
    // R5 load in memory stage falls to WB
    settle(); idle(); ex_rs1 = 4; mem_wr = 1; mem_ld = 1; mem_rd = 4; wb_wr = 1; wb_rd = 4; #10;
    chk("R5 load not source", ex_fa, 1);
    // R6 load-use
    settle(); idle(); ex_wr = 1; ex_ld = 1; ex_rd = 7; id_rs2 = 7; id_u2 = 1; #10;
    chk("R6 hold pc", pc_hold, 1);
    chk("R6 bubble", bubble, 1);
    // R7 store data from load: no stall, then memory-stage bypass
    settle(); idle(); ex_wr = 1; ex_ld = 1; ex_rd = 7; id_rs2 = 7; id_u1 = 1; id_u2 = 1; id_rs1 = 2; id_st = 1; #10;
    chk("R7 no stall", pc_hold, 0);
    settle(); idle(); mem_st = 1; mem_rs2 = 7; wb_wr = 1; wb_rd = 7; #10;
    chk("R7 store fwd", st_fwd, 1);
    // R7 store address from load must stall
    settle(); idle(); ex_wr = 1; ex_ld = 1; ex_rd = 5; id_rs1 = 5; id_u1 = 1; id_u2 = 1; id_st = 1; #10;
    chk("R7 addr stalls", bubble, 1);
    // R8 branch comparator from EX/MEM
    settle(); idle(); id_br = 1; id_rs1 = 8; id_u1 = 1; mem_wr = 1; mem_rd = 8; #10;
    chk("R8 br bypass", id_fa, 2);
    // R9 branch behind ALU in EX, taken: stall, no flush
    settle(); idle(); id_br = 1; id_tk = 1; id_rs2 = 10; id_u2 = 1; ex_wr = 1; ex_rd = 10; #10;
    chk("R9 br ex stall", ifid_hold, 1);
    chk("R10 no flush when stalled", flush, 0);
    // R9 branch behind load in MEM
    settle(); idle(); id_br = 1; id_rs1 = 11; id_u1 = 1; mem_wr = 1; mem_ld = 1; mem_rd = 11; #10;
    chk("R9 br mem load", pc_hold, 1);
    // R10 taken branch flush
    settle(); idle(); id_br = 1; id_tk = 1; id_u1 = 1; id_rs1 = 12; #10;
    chk("R10 flush", flush, 1);
    // R11 unused source ignored
    settle(); idle(); ex_wr = 1; ex_ld = 1; ex_rd = 13; id_rs1 = 13; id_u1 = 0; #10;
    chk("R11 unused", bubble, 0);
    // R12 ALU in EX feeding non-branch
    settle(); idle(); ex_wr = 1; ex_rd = 14; id_rs1 = 14; id_u1 = 1; #10;
    chk("R12 no stall", pc_hold, 0);

    for (int i = 0; i < 3000; i++) begin
      settle();
      id_rs1 = AW'($urandom_range(0, 3)); id_rs2 = AW'($urandom_range(0, 3));
      ex_rs1 = AW'($urandom_range(0, 3)); ex_rs2 = AW'($urandom_range(0, 3));
      ex_rd = AW'($urandom_range(0, 3)); mem_rd = AW'($urandom_range(0, 3));
      mem_rs2 = AW'($urandom_range(0, 3)); wb_rd = AW'($urandom_range(0, 3));
      id_u1 = 1'($urandom); id_u2 = 1'($urandom); id_tk = 1'($urandom);
      id_br = 1'($urandom); id_st = !id_br && 1'($urandom);
      ex_wr = 1'($urandom); ex_ld = ex_wr && 1'($urandom);
      mem_wr = 1'($urandom); mem_ld = mem_wr && 1'($urandom);
      mem_st = !mem_wr && 1'($urandom); wb_wr = 1'($urandom);
      #10;
      check_all("rand");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule